// File: doc/BRIEF.md
# Daisy-Chainable Vectored Interrupt Controller

This block collects up to 32 interrupt request lines and names one winner each cycle. Each line carries a programmable request level, an enable bit and a shadow register-set number. A software trigger bit per line can raise the same request from the register interface. A priority stage compares every active local request against an optional chain input, which is the registered result of an upstream controller of the same kind. A vector stage then builds the outgoing bundle: valid, level, vector address and register set.

The outgoing bundle has the same layout as the chain input, so several instances can be cascaded by wiring one controller's outputs straight into the next controller's chain inputs. When the chain request wins, its fields leave the block untouched. When a local line wins, the vector is a programmable base plus the line index times a programmable table step.

Top module: `vic_chain`

## Requirements
- R1: While `rst` is high at a clock edge, all configuration, software-trigger, base and step registers clear to zero. After that edge `out_valid`, `out_ril`, `out_vector`, `out_rss` and `reg_rdata` are zero.
- R2: A line is pending when its enable bit is set and either its `irq_in` bit or its software-trigger bit is high. `reg_rdata` returns the register addressed by `reg_addr` one clock after the address is presented. Address 0x24 reads the pending bits in bits [N-1:0]. Address 0x20 reads the software-trigger bits. Address 0x22 reads the base and 0x23 reads the step. Address i (i < N) reads line i's configuration. Unmapped addresses read zero.
- R3: A pending line with level 0 never wins, and a chain request whose used level is 0 never wins. With no winner, `out_valid` is low and the other outputs are zero. Whenever `out_valid` is high, `out_ril` is nonzero.
- R4: Among the pending local lines, the highest level wins. On equal levels, the lowest line index wins.
- R5: A local winner at index i drives `out_vector` = base + i*step (modulo 2^VEC_W), `out_rss` = that line's register-set field and `out_ril` = its level. Line configuration is written at address i: level in bits [RIL_W-1:0], enable in bit 7, register set in bits [8+RSS_W-1:8].
- R6: A chain request takes part only when `chain_valid` is high. It wins only if its used level is strictly greater than the best local level, so on a tie the local line wins.
- R7: When the chain request wins, `out_vector` equals `chain_vector`, `out_rss` equals `chain_rss` and `out_ril` equals the used chain level, with `out_valid` high.
- R8: Only the low RIL_W bits of `chain_ril` form the used chain level; the higher bits are dropped.
- R9: A write to address 0x20 sets the software-trigger bits where the write data is 1. A write to 0x21 clears them where the data is 1. Zero bits leave the triggers unchanged. A software trigger arbitrates exactly like a hardware line.
- R10: Outputs are registered. A change on `irq_in` or the chain inputs before a clock edge shows on the outputs after that edge. A register write becomes visible on the outputs one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N | Hardware request lines, level sensitive |
| chain_valid | input | 1 | Upstream controller has a request |
| chain_ril | input | CHAIN_RIL_W | Upstream request level |
| chain_vector | input | VEC_W | Upstream vector address |
| chain_rss | input | RSS_W | Upstream register-set number |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| out_valid | output | 1 | A request is being presented |
| out_ril | output | RIL_W | Level of the presented request |
| out_vector | output | VEC_W | Vector address of the presented request |
| out_rss | output | RSS_W | Register set of the presented request |

## Verification
The embedded properties assume the chain inputs come from a registered upstream stage, so they are treated as ordinary synchronous inputs that may change every cycle. They also assume only one register access per cycle, which keeps set and clear of the software triggers in different cycles. The stimulus drives all inputs at the falling edge. It mixes directed cases (ties, level-0 lines, chain ties, truncated chain levels, software triggers) with a random phase that changes the request lines, the chain bundle and occasional register writes. The random phase uses upstream levels wider than the local width, so the truncation path is exercised.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_SWSET = 6'h20;
  localparam logic [ADDR_W-1:0] A_SWCLR = 6'h21;
  localparam logic [ADDR_W-1:0] A_BASE  = 6'h22;
  localparam logic [ADDR_W-1:0] A_STEP  = 6'h23;
  localparam logic [ADDR_W-1:0] A_PEND  = 6'h24;
  localparam int EN_BIT  = 7;
  localparam int RSS_LSB = 8;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int N     = 8,
  parameter int RIL_W = 4,
  parameter int RSS_W = 6,
  parameter int VEC_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        irq_in,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [N*RIL_W-1:0]  lvl_flat,
  output logic [N*RSS_W-1:0]  rss_flat,
  output logic [N-1:0]        active,
  output logic [VEC_W-1:0]    vec_base,
  output logic [VEC_W-1:0]    vec_step
);
  logic [RIL_W-1:0] lvl_q [N];
  logic [RSS_W-1:0] rss_q [N];
  logic [N-1:0]     en_q;
  logic [N-1:0]     sw_q;
  logic [N-1:0]     pending;
  logic [DATA_W-1:0] rd_n;

  assign pending = (irq_in | sw_q) & en_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_line
      assign lvl_flat[g*RIL_W +: RIL_W] = lvl_q[g];
      assign rss_flat[g*RSS_W +: RSS_W] = rss_q[g];
      assign active[g] = pending[g] && (lvl_q[g] != '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        lvl_q[i] <= '0;
        rss_q[i] <= '0;
      end
      en_q     <= '0;
      sw_q     <= '0;
      vec_base <= '0;
      vec_step <= '0;
    end else if (reg_wr) begin
      for (int i = 0; i < N; i++) begin
        if (reg_addr == ADDR_W'(i)) begin
          lvl_q[i] <= reg_wdata[RIL_W-1:0];
          en_q[i]  <= reg_wdata[EN_BIT];
          rss_q[i] <= reg_wdata[RSS_LSB +: RSS_W];
        end
      end
      case (reg_addr)
        A_SWSET: sw_q     <= sw_q | reg_wdata[N-1:0];
        A_SWCLR: sw_q     <= sw_q & ~reg_wdata[N-1:0];
        A_BASE:  vec_base <= VEC_W'(reg_wdata);
        A_STEP:  vec_step <= VEC_W'(reg_wdata);
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_n = '0;
    for (int i = 0; i < N; i++) begin
      if (reg_addr == ADDR_W'(i)) begin
        rd_n[RIL_W-1:0]           = lvl_q[i];
        rd_n[EN_BIT]              = en_q[i];
        rd_n[RSS_LSB +: RSS_W]    = rss_q[i];
      end
    end
    case (reg_addr)
      A_SWSET: rd_n = DATA_W'(sw_q);
      A_BASE:  rd_n = DATA_W'(vec_base);
      A_STEP:  rd_n = DATA_W'(vec_step);
      A_PEND:  rd_n = DATA_W'(pending);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_n;
  end

  AST_SW_SET: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_SWSET) |=> ((sw_q & $past(reg_wdata[N-1:0])) == $past(reg_wdata[N-1:0]))); // R9
  AST_SW_CLR: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_SWCLR) |=> ((sw_q & $past(reg_wdata[N-1:0])) == '0)); // R9
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N     = 8,
  parameter int RIL_W = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       active,
  input  logic [N*RIL_W-1:0] lvl_flat,
  input  logic               chain_valid,
  input  logic [RIL_W-1:0]   chain_ril_t,
  output logic               loc_valid,
  output logic [IDX_W-1:0]   loc_idx,
  output logic [RIL_W-1:0]   loc_ril,
  output logic               sel_chain
);
  always_comb begin
    loc_ril = '0;
    loc_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (active[i] && (lvl_flat[i*RIL_W +: RIL_W] > loc_ril)) begin
        loc_ril = lvl_flat[i*RIL_W +: RIL_W];
        loc_idx = IDX_W'(i);
      end
    end
    loc_valid = (loc_ril != '0);
    sel_chain = chain_valid && (chain_ril_t > loc_ril);
  end
endmodule

// File: rtl/vic_vecgen.sv
module vic_vecgen #(
  parameter int N     = 8,
  parameter int RIL_W = 4,
  parameter int RSS_W = 6,
  parameter int VEC_W = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               loc_valid,
  input  logic [IDX_W-1:0]   loc_idx,
  input  logic [RIL_W-1:0]   loc_ril,
  input  logic [N*RSS_W-1:0] rss_flat,
  input  logic [VEC_W-1:0]   vec_base,
  input  logic [VEC_W-1:0]   vec_step,
  input  logic               sel_chain,
  input  logic [RIL_W-1:0]   chain_ril_t,
  input  logic [VEC_W-1:0]   chain_vector,
  input  logic [RSS_W-1:0]   chain_rss,
  output logic               out_valid,
  output logic [RIL_W-1:0]   out_ril,
  output logic [VEC_W-1:0]   out_vector,
  output logic [RSS_W-1:0]   out_rss
);
  logic [VEC_W-1:0] loc_vector;
  logic [RSS_W-1:0] loc_rss;

  assign loc_vector = vec_base + (VEC_W'(loc_idx) * vec_step);
  assign loc_rss    = rss_flat[32'(loc_idx) * RSS_W +: RSS_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_ril    <= '0;
      out_vector <= '0;
      out_rss    <= '0;
    end else if (sel_chain) begin
      out_valid  <= 1'b1;
      out_ril    <= chain_ril_t;
      out_vector <= chain_vector;
      out_rss    <= chain_rss;
    end else if (loc_valid) begin
      out_valid  <= 1'b1;
      out_ril    <= loc_ril;
      out_vector <= loc_vector;
      out_rss    <= loc_rss;
    end else begin
      out_valid  <= 1'b0;
      out_ril    <= '0;
      out_vector <= '0;
      out_rss    <= '0;
    end
  end
endmodule

// File: rtl/vic_chain.sv
module vic_chain
  import vic_pkg::*;
#(
  parameter int N           = 8,
  parameter int RIL_W       = 4,
  parameter int CHAIN_RIL_W = 6,
  parameter int RSS_W       = 6,
  parameter int VEC_W       = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N-1:0]           irq_in,
  input  logic                   chain_valid,
  input  logic [CHAIN_RIL_W-1:0] chain_ril,
  input  logic [VEC_W-1:0]       chain_vector,
  input  logic [RSS_W-1:0]       chain_rss,
  input  logic                   reg_wr,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  output logic                   out_valid,
  output logic [RIL_W-1:0]       out_ril,
  output logic [VEC_W-1:0]       out_vector,
  output logic [RSS_W-1:0]       out_rss
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [RIL_W-1:0]   chain_ril_t;
  logic [N*RIL_W-1:0] lvl_flat;
  logic [N*RSS_W-1:0] rss_flat;
  logic [N-1:0]       active;
  logic [VEC_W-1:0]   vec_base, vec_step;
  logic               loc_valid, sel_chain;
  logic [IDX_W-1:0]   loc_idx;
  logic [RIL_W-1:0]   loc_ril;

  generate
    if (CHAIN_RIL_W >= RIL_W) begin : g_trunc
      assign chain_ril_t = chain_ril[RIL_W-1:0];
      if (CHAIN_RIL_W > RIL_W) begin : g_drop
        logic unused_chain_hi;
        assign unused_chain_hi = ^chain_ril[CHAIN_RIL_W-1:RIL_W];
      end
    end else begin : g_ext
      assign chain_ril_t = {{(RIL_W-CHAIN_RIL_W){1'b0}}, chain_ril};
    end
  endgenerate

  vic_regs #(.N(N), .RIL_W(RIL_W), .RSS_W(RSS_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lvl_flat(lvl_flat), .rss_flat(rss_flat), .active(active),
    .vec_base(vec_base), .vec_step(vec_step)
  );

  vic_prio #(.N(N), .RIL_W(RIL_W)) u_prio (
    .active(active), .lvl_flat(lvl_flat),
    .chain_valid(chain_valid), .chain_ril_t(chain_ril_t),
    .loc_valid(loc_valid), .loc_idx(loc_idx), .loc_ril(loc_ril), .sel_chain(sel_chain)
  );

  vic_vecgen #(.N(N), .RIL_W(RIL_W), .RSS_W(RSS_W), .VEC_W(VEC_W)) u_vec (
    .clk(clk), .rst(rst),
    .loc_valid(loc_valid), .loc_idx(loc_idx), .loc_ril(loc_ril), .rss_flat(rss_flat),
    .vec_base(vec_base), .vec_step(vec_step),
    .sel_chain(sel_chain), .chain_ril_t(chain_ril_t),
    .chain_vector(chain_vector), .chain_rss(chain_rss),
    .out_valid(out_valid), .out_ril(out_ril), .out_vector(out_vector), .out_rss(out_rss)
  );

  AST_CHAIN_STRICT: assert property (@(posedge clk) disable iff (rst)
    sel_chain |-> (chain_ril_t > loc_ril)); // R6
  AST_CHAIN_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    sel_chain |=> (out_valid && out_vector == $past(chain_vector) &&
                   out_rss == $past(chain_rss) && out_ril == $past(chain_ril[RIL_W-1:0]))); // R7
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (active == '0 && !(chain_valid && chain_ril_t != '0)) |=> !out_valid); // R3
  AST_VALID_RIL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_ril != '0)); // R3
endmodule

// File: tb/vic_chain_tb.sv
module vic_chain_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  irq_in = '0;
  logic        chain_valid = 1'b0;
  logic [5:0]  chain_ril = '0;
  logic [31:0] chain_vector = '0;
  logic [5:0]  chain_rss = '0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        out_valid;
  logic [3:0]  out_ril;
  logic [31:0] out_vector;
  logic [5:0]  out_rss;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_chain u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .chain_valid(chain_valid), .chain_ril(chain_ril), .chain_vector(chain_vector), .chain_rss(chain_rss),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .out_valid(out_valid), .out_ril(out_ril), .out_vector(out_vector), .out_rss(out_rss)
  );

  // behavioural reference state
  int          lvl_m [N];
  int          rss_m [N];
  bit          en_m  [N];
  bit          sw_m  [N];
  logic [31:0] base_m, step_m;
  bit          e_valid, e_chain;
  int          e_ril, e_rss;
  logic [31:0] e_vec, e_rdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int best, bidx, ct;
    logic [31:0] rd;
    if (rst) begin
      for (int i = 0; i < N; i++) begin lvl_m[i] = 0; rss_m[i] = 0; en_m[i] = 0; sw_m[i] = 0; end
      base_m = 0; step_m = 0;
      e_valid = 0; e_chain = 0; e_ril = 0; e_rss = 0; e_vec = 0; e_rdata = 0;
    end else begin
      best = 0; bidx = -1;
      for (int i = 0; i < N; i++)
        if (en_m[i] && (irq_in[i] || sw_m[i]) && lvl_m[i] > best) begin best = lvl_m[i]; bidx = i; end
      ct = chain_ril % 16;
      e_chain = 0;
      if (chain_valid && ct > best) begin
        e_valid = 1; e_chain = 1; e_ril = ct; e_vec = chain_vector; e_rss = chain_rss;
      end else if (bidx >= 0) begin
        e_valid = 1; e_ril = best; e_vec = base_m + step_m * bidx; e_rss = rss_m[bidx];
      end else begin
        e_valid = 0; e_ril = 0; e_vec = 0; e_rss = 0;
      end
      rd = 0;
      if (reg_addr < N) rd = lvl_m[reg_addr] + (en_m[reg_addr] ? 128 : 0) + rss_m[reg_addr] * 256;
      else if (reg_addr == 6'h20) begin for (int i = 0; i < N; i++) rd[i] = sw_m[i]; end
      else if (reg_addr == 6'h22) rd = base_m;
      else if (reg_addr == 6'h23) rd = step_m;
      else if (reg_addr == 6'h24) begin for (int i = 0; i < N; i++) rd[i] = en_m[i] && (irq_in[i] || sw_m[i]); end
      e_rdata = rd;
      if (reg_wr) begin
        if (reg_addr < N) begin
          lvl_m[reg_addr] = reg_wdata[3:0]; en_m[reg_addr] = reg_wdata[7]; rss_m[reg_addr] = reg_wdata[13:8];
        end else if (reg_addr == 6'h20) begin for (int i = 0; i < N; i++) if (reg_wdata[i]) sw_m[i] = 1; end
        else if (reg_addr == 6'h21) begin for (int i = 0; i < N; i++) if (reg_wdata[i]) sw_m[i] = 0; end
        else if (reg_addr == 6'h22) base_m = reg_wdata;
        else if (reg_addr == 6'h23) step_m = reg_wdata;
      end
    end
  end

  // per-cycle comparison against the model (R10: one-edge latency is implied)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 valid", 32'(out_valid), 32'(e_valid));
      chk("R4 ril", 32'(out_ril), 32'(e_ril));
      chk(e_chain ? "R7 vector" : "R5 vector", out_vector, e_vec);
      chk(e_chain ? "R7 rss" : "R5 rss", 32'(out_rss), 32'(e_rss));
      chk("R2 rdata", reg_rdata, e_rdata);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  function automatic logic [31:0] cfg(input int lvl, input bit en, input int rs);
    return 32'(lvl) | (en ? 32'h80 : 32'h0) | (32'(rs) << 8);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", 32'(out_valid), 0);
    chk("R1 vector after reset", out_vector, 0);
    rst = 1'b0;
    rd(6'h00, d); chk("R1 cfg cleared", d, 0);

    wr(6'h22, 32'h1000); wr(6'h23, 32'h10);
    wr(6'h02, cfg(5, 1, 3)); wr(6'h05, cfg(5, 1, 7));
    wr(6'h06, cfg(9, 1, 1)); wr(6'h01, cfg(0, 1, 2));
    @(negedge clk);
    irq_in = 8'b0010_0100;
    @(negedge clk);
    chk("R4 tie lowest index", out_vector, 32'h1020);
    chk("R5 rss of winner", 32'(out_rss), 3);
    irq_in = 8'b0110_0100;
    chk("R10 not yet updated", out_vector, 32'h1020);
    @(negedge clk);
    chk("R4 highest level", out_vector, 32'h1060);
    chk("R4 level out", 32'(out_ril), 9);
    irq_in = 8'b0000_0010;
    @(negedge clk);
    chk("R3 level zero ignored", 32'(out_valid), 0);

    irq_in = 8'b0100_0000;
    chain_valid = 1'b1; chain_ril = 6'h09; chain_vector = 32'hDEAD0000; chain_rss = 6'h2A;
    @(negedge clk);
    chk("R6 tie goes local", out_vector, 32'h1060);
    chain_ril = 6'h0A;
    @(negedge clk);
    chk("R7 chain vector", out_vector, 32'hDEAD0000);
    chk("R7 chain rss", 32'(out_rss), 32'h2A);
    chk("R7 chain ril", 32'(out_ril), 32'hA);
    chain_valid = 1'b0;
    @(negedge clk);
    chk("R6 invalid chain ignored", out_vector, 32'h1060);
    irq_in = '0; chain_valid = 1'b1; chain_ril = 6'h30;
    @(negedge clk);
    chk("R8 truncated to zero", 32'(out_valid), 0);
    chain_ril = 6'h1A;
    @(negedge clk);
    chk("R8 upper bits dropped", 32'(out_ril), 32'hA);
    chain_valid = 1'b0;

    wr(6'h20, 32'h04);
    @(negedge clk);
    chk("R9 sw trigger wins", out_vector, 32'h1020);
    wr(6'h20, 32'h00);
    rd(6'h20, d); chk("R9 zero set no effect", d, 32'h04);
    irq_in = 8'b0010_0000;
    rd(6'h24, d); chk("R2 pending readback", d, 32'h24);
    wr(6'h21, 32'h04);
    rd(6'h20, d); chk("R9 sw cleared", d, 0);
    irq_in = '0;
    @(negedge clk);
    chk("R9 idle after clear", 32'(out_valid), 0);
    rd(6'h2F, d); chk("R2 unmapped reads zero", d, 0);

    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      irq_in = 8'($urandom);
      chain_valid = 1'($urandom);
      chain_ril = 6'($urandom);
      chain_vector = $urandom;
      chain_rss = 6'($urandom);
      reg_addr = 6'($urandom_range(0, 40));
      reg_wdata = $urandom;
      reg_wr = ($urandom_range(0, 7) == 0);
    end
    @(negedge clk); reg_wr = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule